// File: doc/BRIEF.md
# Oversampled Phase Picker

This block sits after a set of eight sampling phases that watch one serial stream at evenly spaced points, 45 degrees apart across a single bit period. It is meant for a receiver that runs without a reference clock for the incoming data, at rates around 312 MHz. The eight phases come from four delayed copies of the line, each captured on both clock edges. For each frame an upstream matcher reports, for every phase, whether that phase saw the expected pattern. This block takes that 8-bit hit vector and decides which phase should forward data.

A healthy alignment gives a single unbroken run of hitting phases that is neither a lone phase nor all eight. The run is counted around the circle, so phase 7 is followed by phase 0. The block picks the phase that saw the data earliest: the member of the run whose circular predecessor missed. A good selection is registered with a one-cycle strobe. A broken run, a full house or a lone hit each raise their own one-cycle error flag, and none of them moves the stored phase index.

Top module: `phase_picker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `pick_valid`, `fault_gap`, `fault_all` and `fault_lone` are 0 and `pick_phase` is 0.
- R2: A hit vector is taken on a clock edge where `hits_valid` is 1. Its result shows on the outputs for exactly the next cycle. With `hits_valid` at 0 the hit vector is ignored: no strobe or flag rises and `pick_phase` keeps its value.
- R3: Bit i of `hits` belongs to phase i. For a valid vector that forms one circular run of 2 to 7 hitting phases, `pick_valid` pulses. `pick_phase` becomes the run member i whose predecessor (i+7) mod 8 has a 0 in `hits`.
- R4: A run that wraps from phase 7 to phase 0 counts as one run. For example, 8'h83 selects phase 7 and 8'h81 selects phase 7.
- R5: A valid vector whose hitting phases form two or more separate circular runs pulses `fault_gap` and does not pulse `pick_valid`.
- R6: A valid vector with all eight bits set pulses `fault_all`, and no phase is selected.
- R7: A valid vector with exactly one bit set pulses `fault_lone`, and no phase is selected.
- R8: A valid vector of all zeros produces no strobe and no flag.
- R9: `pick_phase` changes only together with a `pick_valid` pulse. After any rejected or empty vector it holds the last good index.
- R10: In any cycle, at most one of `pick_valid`, `fault_gap`, `fault_all` and `fault_lone` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hits_valid | input | 1 | Qualifies `hits` for this cycle |
| hits | input | 8 | Per-phase detection flags, bit i for phase i |
| pick_valid | output | 1 | One-cycle strobe for a good selection |
| pick_phase | output | 3 | Selected phase index, held between selections |
| fault_gap | output | 1 | One-cycle flag: hitting phases are not contiguous |
| fault_all | output | 1 | One-cycle flag: every phase hit |
| fault_lone | output | 1 | One-cycle flag: a single phase hit |

## Verification
A wrong leading-edge decode shows up as a wrong `pick_phase` in the very cycle after the vector is taken. Wrapping runs such as 8'h83 are most exposed to this fault. A bad verdict shows up in the same cycle, either as a strobe where a flag belongs or as two outputs high together. An index register that updates on a rejected vector does not show at once. It appears on the next cycle and on every later cycle until a good selection overwrites it, so the comparison on every clock catches it however late the mistake happened.

// File: rtl/phase_picker_pkg.sv
package phase_picker_pkg;

    localparam int PHASES  = 8;
    localparam int IDX_W   = $clog2(PHASES);
    localparam int CNT_W   = IDX_W + 1;

    // outcome of judging one hit vector
    typedef struct packed {
        logic good;
        logic gap;
        logic all_hit;
        logic lone;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{good: 1'b0, gap: 1'b0, all_hit: 1'b0, lone: 1'b0};

    // circular predecessor of a phase
    function automatic int prev_phase(input int idx, input int n);
        return (idx + n - 1) % n;
    endfunction

endpackage

// File: rtl/phase_run_scan.sv
module phase_run_scan
    import phase_picker_pkg::*;
#(
    parameter int N  = PHASES,
    parameter int CW = $clog2(N) + 1
) (
    input  logic [N-1:0]  hits,
    output logic [N-1:0]  lead_mask,
    output logic [CW-1:0] hit_cnt,
    output logic [CW-1:0] lead_cnt
);

    // a run starts where a hit follows a miss, going round the circle
    for (genvar g = 0; g < N; g++) begin : g_lead
        assign lead_mask[g] = hits[g] & ~hits[prev_phase(g, N)];
    end

    always_comb begin
        hit_cnt  = '0;
        lead_cnt = '0;
        for (int i = 0; i < N; i++) begin
            hit_cnt  = hit_cnt  + CW'(hits[i]);
            lead_cnt = lead_cnt + CW'(lead_mask[i]);
        end
    end

endmodule

// File: rtl/phase_lead_encode.sv
module phase_lead_encode #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  lead_mask,
    output logic [IW-1:0] lead_idx
);

    // lowest set bit wins; only used when exactly one is set
    always_comb begin
        lead_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lead_mask[i]) lead_idx = IW'(i);
        end
    end

endmodule

// File: rtl/phase_picker.sv
module phase_picker
    import phase_picker_pkg::*;
#(
    parameter int N  = PHASES,
    localparam int IW = $clog2(N),
    localparam int CW = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hits_valid,
    input  logic [N-1:0]  hits,
    output logic          pick_valid,
    output logic [IW-1:0] pick_phase,
    output logic          fault_gap,
    output logic          fault_all,
    output logic          fault_lone
);

    logic [N-1:0]  lead_mask;
    logic [CW-1:0] hit_cnt;
    logic [CW-1:0] lead_cnt;
    logic [IW-1:0] lead_idx;
    verdict_t      verdict_d;
    verdict_t      verdict_q;
    logic [IW-1:0] phase_q;

    phase_run_scan #(.N(N), .CW(CW)) u_scan (
        .hits      (hits),
        .lead_mask (lead_mask),
        .hit_cnt   (hit_cnt),
        .lead_cnt  (lead_cnt)
    );

    phase_lead_encode #(.N(N), .IW(IW)) u_enc (
        .lead_mask (lead_mask),
        .lead_idx  (lead_idx)
    );

    // judge the vector: full house and lone hit take precedence over run count
    always_comb begin
        verdict_d = VERDICT_IDLE;
        if (hits_valid) begin
            if (hit_cnt == CW'(N))          verdict_d.all_hit = 1'b1;
            else if (hit_cnt == CW'(1))     verdict_d.lone    = 1'b1;
            else if (lead_cnt > CW'(1))     verdict_d.gap     = 1'b1;
            else if (lead_cnt == CW'(1))    verdict_d.good    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= VERDICT_IDLE;
            phase_q   <= '0;
        end else begin
            verdict_q <= verdict_d;
            if (verdict_d.good) phase_q <= lead_idx;
        end
    end

    assign pick_valid = verdict_q.good;
    assign fault_gap  = verdict_q.gap;
    assign fault_all  = verdict_q.all_hit;
    assign fault_lone = verdict_q.lone;
    assign pick_phase = phase_q;

    // registered copy of the accepted vector, for the checks below
    logic [N-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else     seen_q <= hits;
    end

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pick_valid, fault_gap, fault_all, fault_lone}));

    // R2
    outcome_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        (pick_valid || fault_gap || fault_all || fault_lone) |-> $past(hits_valid));

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pick_valid |-> $stable(pick_phase));

    // R3
    lead_edge_chk: assert property (@(posedge clk) disable iff (rst)
        pick_valid |-> (seen_q[pick_phase] && !seen_q[pick_phase - 1'b1]));

    // R6
    all_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fault_all |-> ($past(hits) == {N{1'b1}}));

    // R7
    lone_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fault_lone |-> ($countones($past(hits)) == 1));

endmodule

// File: tb/test_phase_picker.sv
`timescale 1ns/1ps
module test_phase_picker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hits_valid = 1'b0;
    logic [7:0] hits = '0;
    logic       pick_valid;
    logic [2:0] pick_phase;
    logic       fault_gap, fault_all, fault_lone;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected outputs for the coming cycle
    bit       e_valid, e_gap, e_all, e_lone;
    int       e_phase;
    string    e_tag;

    always #10 clk = ~clk;

    phase_picker i_phase_picker (
        .clk        (clk),
        .rst        (rst),
        .hits_valid (hits_valid),
        .hits       (hits),
        .pick_valid (pick_valid),
        .pick_phase (pick_phase),
        .fault_gap  (fault_gap),
        .fault_all  (fault_all),
        .fault_lone (fault_lone)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "pick_valid", int'(pick_valid), int'(e_valid));
        check(req, "fault_gap",  int'(fault_gap),  int'(e_gap));
        check(req, "fault_all",  int'(fault_all),  int'(e_all));
        check(req, "fault_lone", int'(fault_lone), int'(e_lone));
        check(req, "pick_phase", int'(pick_phase), e_phase);
        // R10
        check("R10", "outcome count",
              int'(pick_valid) + int'(fault_gap) + int'(fault_all) + int'(fault_lone),
              (int'(pick_valid) + int'(fault_gap) + int'(fault_all) + int'(fault_lone) > 1) ? 1 : 
              int'(pick_valid) + int'(fault_gap) + int'(fault_all) + int'(fault_lone));
    endtask

    // behavioural reference: walk the circle starting just after a miss
    task automatic predict(input bit v, input logic [7:0] f, input string req);
        int ones, zero_at, runs, lead;
        bit prev;
        e_valid = 0; e_gap = 0; e_all = 0; e_lone = 0;
        e_tag = req;
        if (!v) return;
        ones = 0;
        zero_at = -1;
        for (int k = 0; k < 8; k++) begin
            if (f[k]) ones++;
            else if (zero_at < 0) zero_at = k;
        end
        if (ones == 0) return;
        if (ones == 8) begin e_all = 1; return; end
        if (ones == 1) begin e_lone = 1; return; end
        runs = 0;
        lead = 0;
        prev = 0;
        for (int k = 1; k <= 8; k++) begin
            int p;
            p = (zero_at + k) % 8;
            if (f[p] && !prev) begin
                runs++;
                if (runs == 1) lead = p;
            end
            prev = f[p];
        end
        if (runs > 1) e_gap = 1;
        else begin
            e_valid = 1;
            e_phase = lead;
        end
    endtask

    // check the previous cycle's result, then drive the next vector
    task automatic step(input bit v, input logic [7:0] f, input string req);
        @(negedge clk);
        compare_all(e_tag);
        hits_valid = v;
        hits = f;
        predict(v, f, req);
    endtask

    initial begin
        e_valid = 0; e_gap = 0; e_all = 0; e_lone = 0; e_phase = 0; e_tag = "R1";
        repeat (3) @(negedge clk);
        // R1 during reset
        compare_all("R1");
        rst = 1'b0;
        step(1'b0, 8'h00, "R1");          // R1 first cycle after reset
        step(1'b1, 8'h0E, "R3");          // phases 1..3 -> 1
        step(1'b1, 8'h83, "R4");          // 7,0,1 -> 7
        step(1'b1, 8'h81, "R4");          // 7,0 -> 7
        step(1'b1, 8'hC0, "R3");          // 6,7 -> 6
        step(1'b1, 8'h55, "R5");          // gapped
        step(1'b1, 8'h66, "R5");          // two runs, index held (R9)
        step(1'b1, 8'hFF, "R6");
        step(1'b1, 8'h10, "R7");
        step(1'b1, 8'h00, "R8");
        step(1'b1, 8'h7F, "R3");          // 0..6 -> 0
        step(1'b0, 8'h38, "R2");          // ignored vector
        step(1'b0, 8'hFF, "R2");
        step(1'b1, 8'hFE, "R3");          // 1..7 -> 1
        step(1'b1, 8'h01, "R9");          // rejected, index held
        step(1'b0, 8'h00, "R9");
        for (int n = 0; n < 400; n++) begin
            bit v;
            logic [7:0] f;
            v = ($urandom_range(0, 3) != 0);
            f = 8'($urandom);
            if (n % 3 == 0) begin
                int s, len;
                s = $urandom_range(0, 7);
                len = $urandom_range(1, 8);
                f = '0;
                for (int k = 0; k < len; k++) f[(s + k) % 8] = 1'b1;
            end
            step(v, f, "R3");
        end
        step(1'b0, 8'h00, "R2");
        step(1'b0, 8'h00, "R9");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule